// File: doc/BRIEF.md
# Linked-List Command Chain Walker

The walker follows a chain of command packets stored in memory and streams each packet's payload to a peripheral. Every packet starts with one header word. The header's top byte holds the number of 32-bit payload words that follow it. Its low 24 bits point at the next packet. The walker reads a header, reads each payload word and hands it to the peripheral with a valid/ready handshake, then follows the pointer.

A walk starts with a one-cycle start pulse, a start address and a channel-control word that selects linked-list mode. The walk ends in one of three ways:
- an end marker in a next pointer;
- a revisited address, caught by a three-entry address history;
- a node-count limit, which backs up the history when it misses a long cycle.

When the walk ends, the block reports three results: the total number of words consumed, the final pointer and the cause of the stop. It then drops busy and pulses done for one cycle.

Top module: `chain_walker`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `mem_req_o` and `per_valid_o` are 0, and `words_o`, `final_ptr_o` and `cause_o` are 0.
- R2: A walk starts only when `start_i` is high while the block is idle and `ctrl_i` equals 32'h0100_0401. Any other control value leaves the block idle: no busy, no memory request, no done.
- R3: A header word has bits 31:24 = payload count and bits 23:0 = next pointer. The payload words are read from the consecutive word addresses after the header. They are sent in order on `per_data_o`, and `per_data_o` is held stable while `per_valid_o` waits for `per_ready_i`.
- R4: A node whose payload count is 0 produces no peripheral beat, and the walker goes straight on to its next pointer.
- R5: Every address on `mem_addr_o` lies within the 2 MB window and is word aligned. A node is fetched at its pointer ANDed with 24'h1FFFFC, and payload addresses wrap inside that mask.
- R6: The walk ends when a next pointer has bit 23 set, whatever its other bits are. `final_ptr_o` then holds that pointer and `cause_o` = 0.
- R7: The history holds a last address, a low mark and a high mark, all set to 24'hFFFFFF at start. Before each node is fetched, its masked address is compared with both marks.
  - On a match, the walk stops without fetching the node, with `cause_o` = 1 and `final_ptr_o` = the unmasked pointer that led there.
  - Otherwise, the address replaces the low mark if it is below the last address, and the high mark if not. It then becomes the last address.
- R8: At most MAX_NODES headers are fetched per walk. When the limit is reached and a further node is due, the walk stops with `cause_o` = 2 and `final_ptr_o` = that node's pointer. The limit check comes before the loop check.
- R9: `words_o` = 1 + the sum over fetched nodes of (payload count + 1).
- R10: On completion, `busy_o` falls and `done_o` is high for exactly that one cycle. The results hold until the next completion. A start pulse during a walk is ignored.
- R11: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_ack_i`, and `mem_rdata_i` is taken in the cycle of the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start pulse |
| ctrl_i | input | 32 | Channel-control word; 32'h0100_0401 selects list mode |
| start_addr_i | input | 24 | Address of the first node |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 24 | Memory byte address |
| mem_ack_i | input | 1 | Read acknowledge, data valid |
| mem_rdata_i | input | 32 | Read data |
| per_valid_o | output | 1 | Payload word valid |
| per_data_o | output | 32 | Payload word |
| per_ready_i | input | 1 | Peripheral accepts the word |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| words_o | output | 32 | Words consumed by the last walk |
| final_ptr_o | output | 24 | Pointer at which the last walk stopped |
| cause_o | output | 2 | 0 end marker, 1 loop, 2 node limit |

## Verification
A wrong loop-history state either stops a walk early or lets it go round again. Both show up at once at the ports: the peripheral stream carries too few or too many beats, and `words_o`, `final_ptr_o` and `cause_o` at the done pulse are wrong. The descending two-node cycle exercises the history most sharply, because it must be fetched three times before it stops. A mistracked payload counter or address step shows up on the very next peripheral beat, as a wrong or extra data word. A lost end-marker test appears as a fetch from an unexpected address or as a done that never comes.

// File: rtl/chain_walker_pkg.sv
package chain_walker_pkg;
  localparam int unsigned PTR_W  = 24;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LEN_W  = 8;
  localparam logic [WORD_W-1:0] LIST_MODE = 32'h0100_0401;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_HDR, S_PRD, S_PWR, S_TAIL
  } walk_state_e;

  typedef enum logic [1:0] {
    STOP_END  = 2'd0,
    STOP_LOOP = 2'd1,
    STOP_CAP  = 2'd2
  } stop_cause_e;

  // Node address: pointer folded into the word-aligned window.
  function automatic logic [PTR_W-1:0] fold_addr(input logic [PTR_W-1:0] p,
                                                 input logic [PTR_W-1:0] mask);
    return p & mask;
  endfunction

  // Next payload word address, wrapping inside the window.
  function automatic logic [PTR_W-1:0] step_addr(input logic [PTR_W-1:0] a,
                                                 input logic [PTR_W-1:0] mask);
    return (a + PTR_W'(4)) & mask;
  endfunction

  // Running consumption: payload words plus one header word.
  function automatic logic [WORD_W-1:0] add_node(input logic [WORD_W-1:0] acc,
                                                 input logic [LEN_W-1:0] n);
    return acc + WORD_W'(n) + WORD_W'(1);
  endfunction
endpackage

// File: rtl/chain_loop_guard.sv
module chain_loop_guard #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         commit_i,
  input  logic [W-1:0] probe_i,
  output logic         hit_o
);
  localparam logic [W-1:0] UNSEEN = '1;
  localparam int unsigned  N_MARK = 2;

  logic [W-1:0] last_q;
  logic [W-1:0] mark_q [N_MARK];
  logic [N_MARK-1:0] eq;
  logic below;

  assign below = probe_i < last_q;

  // One comparator and one storage register per mark.
  // Mark 0 is the low mark and takes addresses below the last one;
  // mark 1 is the high mark and takes the others.
  for (genvar g = 0; g < N_MARK; g++) begin : g_mark
    assign eq[g] = (probe_i == mark_q[g]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mark_q[g] <= UNSEEN;
      else if (clear_i) mark_q[g] <= UNSEEN;
      else if (commit_i && (below == (g == 0))) mark_q[g] <= probe_i;
    end
  end

  assign hit_o = |eq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        last_q <= UNSEEN;
    else if (clear_i)  last_q <= UNSEEN;
    else if (commit_i) last_q <= probe_i;
  end
endmodule

// File: rtl/chain_node_limit.sv
module chain_node_limit #(
  parameter int unsigned LIMIT = 2000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic bump_i,
  output logic full_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  assign full_o = (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (clear_i)            cnt_q <= '0;
    else if (bump_i && !full_o)  cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/chain_walker.sv
module chain_walker
  import chain_walker_pkg::*;
#(
  parameter int unsigned       MAX_NODES   = 2000000,
  parameter logic [PTR_W-1:0]  WINDOW_MASK = 24'h1F_FFFC,
  parameter int unsigned       END_BIT     = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] ctrl_i,
  input  logic [PTR_W-1:0]  start_addr_i,
  output logic              mem_req_o,
  output logic [PTR_W-1:0]  mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              per_valid_o,
  output logic [WORD_W-1:0] per_data_o,
  input  logic              per_ready_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] words_o,
  output logic [PTR_W-1:0]  final_ptr_o,
  output logic [1:0]        cause_o
);
  localparam int unsigned LEN_LSB = WORD_W - LEN_W;

  walk_state_e state_q;
  logic [PTR_W-1:0]  cur_ptr_q, nxt_ptr_q, addr_q;
  logic [WORD_W-1:0] data_q, acc_q;
  logic [LEN_W-1:0]  left_q;

  // Named internal events, observed by the checker.
  logic start_ok, node_commit, loop_hit, cap_full;
  logic stop_loop, stop_cap, stop_end, finish;
  logic [PTR_W-1:0] node_a, fin_ptr;
  stop_cause_e      fin_cause;
  logic [LEN_W-1:0] hdr_len;

  assign node_a  = fold_addr(cur_ptr_q, WINDOW_MASK);
  assign hdr_len = mem_rdata_i[WORD_W-1:LEN_LSB];

  assign start_ok    = (state_q == S_IDLE) && start_i && (ctrl_i == LIST_MODE);
  assign stop_cap    = (state_q == S_CHECK) && cap_full;
  assign stop_loop   = (state_q == S_CHECK) && !cap_full && loop_hit;
  assign node_commit = (state_q == S_CHECK) && !cap_full && !loop_hit;
  assign stop_end    = (state_q == S_TAIL) && nxt_ptr_q[END_BIT];
  assign finish      = stop_cap || stop_loop || stop_end;

  always_comb begin
    fin_ptr   = cur_ptr_q;
    fin_cause = STOP_END;
    if (stop_cap)       fin_cause = STOP_CAP;
    else if (stop_loop) fin_cause = STOP_LOOP;
    else if (stop_end)  fin_ptr   = nxt_ptr_q;
  end

  chain_loop_guard #(.W(PTR_W)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (start_ok),
    .commit_i (node_commit),
    .probe_i  (node_a),
    .hit_o    (loop_hit)
  );

  chain_node_limit #(.LIMIT(MAX_NODES)) u_limit (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_ok),
    .bump_i  (node_commit),
    .full_o  (cap_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      cur_ptr_q   <= '0;
      nxt_ptr_q   <= '0;
      addr_q      <= '0;
      data_q      <= '0;
      acc_q       <= '0;
      left_q      <= '0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      words_o     <= '0;
      final_ptr_o <= '0;
      cause_o     <= '0;
    end else begin
      done_o <= 1'b0;
      if (finish) begin
        state_q     <= S_IDLE;
        busy_o      <= 1'b0;
        done_o      <= 1'b1;
        words_o     <= acc_q;
        final_ptr_o <= fin_ptr;
        cause_o     <= fin_cause;
      end else begin
        unique case (state_q)
          S_IDLE: if (start_ok) begin
            cur_ptr_q <= start_addr_i;
            acc_q     <= WORD_W'(1);
            busy_o    <= 1'b1;
            state_q   <= S_CHECK;
          end
          S_CHECK: begin
            addr_q  <= node_a;
            state_q <= S_HDR;
          end
          S_HDR: if (mem_ack_i) begin
            acc_q     <= add_node(acc_q, hdr_len);
            nxt_ptr_q <= mem_rdata_i[PTR_W-1:0];
            left_q    <= hdr_len;
            if (hdr_len == '0) state_q <= S_TAIL;
            else begin
              addr_q  <= step_addr(addr_q, WINDOW_MASK);
              state_q <= S_PRD;
            end
          end
          S_PRD: if (mem_ack_i) begin
            data_q  <= mem_rdata_i;
            state_q <= S_PWR;
          end
          S_PWR: if (per_ready_i) begin
            left_q <= left_q - LEN_W'(1);
            if (left_q == LEN_W'(1)) state_q <= S_TAIL;
            else begin
              addr_q  <= step_addr(addr_q, WINDOW_MASK);
              state_q <= S_PRD;
            end
          end
          S_TAIL: begin
            cur_ptr_q <= nxt_ptr_q;
            state_q   <= S_CHECK;
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign mem_req_o   = (state_q == S_HDR) || (state_q == S_PRD);
  assign mem_addr_o  = addr_q;
  assign per_valid_o = (state_q == S_PWR);
  assign per_data_o  = data_q;
endmodule

// File: rtl/chain_walker_checker.sv
module chain_walker_checker #(
  parameter int unsigned MAX_NODES   = 2000000,
  parameter logic [23:0] WINDOW_MASK = 24'h1F_FFFC,
  parameter int unsigned END_BIT     = 23
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        mem_req_o,
  input logic [23:0] mem_addr_o,
  input logic        mem_ack_i,
  input logic        per_valid_o,
  input logic [31:0] per_data_o,
  input logic        per_ready_i,
  input logic        busy_o,
  input logic        done_o,
  input logic [23:0] final_ptr_o,
  input logic [1:0]  cause_o,
  input logic        node_commit,
  input logic        start_ok
);
  localparam int unsigned CW = $clog2(MAX_NODES + 1);
  logic [CW-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           seen_q <= '0;
    else if (start_ok)    seen_q <= '0;
    else if (node_commit) seen_q <= seen_q + CW'(1);
  end

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));

  assert_beat_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    per_valid_o && !per_ready_i |=> per_valid_o && $stable(per_data_o));

  assert_addr_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> ((mem_addr_o & ~WINDOW_MASK) == 24'h0));

  assert_end_marker_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && (cause_o == 2'd0) |-> final_ptr_o[END_BIT]);

  assert_done_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  assert_node_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    node_commit |-> (seen_q < CW'(MAX_NODES)));

  assert_one_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_o && per_valid_o));
endmodule

bind chain_walker chain_walker_checker #(
  .MAX_NODES   (MAX_NODES),
  .WINDOW_MASK (WINDOW_MASK),
  .END_BIT     (END_BIT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ack_i   (mem_ack_i),
  .per_valid_o (per_valid_o),
  .per_data_o  (per_data_o),
  .per_ready_i (per_ready_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .final_ptr_o (final_ptr_o),
  .cause_o     (cause_o),
  .node_commit (node_commit),
  .start_ok    (start_ok)
);

// File: tb/chain_walker_bench.sv
module chain_walker_bench;
  localparam int unsigned CAP  = 6;
  localparam logic [23:0] MASK = 24'h1F_FFFC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] ctrl_i = '0;
  logic [23:0] start_addr_i = '0;
  logic        mem_req_o, mem_ack_i = 1'b0;
  logic [23:0] mem_addr_o;
  logic [31:0] mem_rdata_i = '0;
  logic        per_valid_o, per_ready_i = 1'b0;
  logic [31:0] per_data_o;
  logic        busy_o, done_o;
  logic [31:0] words_o;
  logic [23:0] final_ptr_o;
  logic [1:0]  cause_o;

  chain_walker #(.MAX_NODES(CAP)) u_chain_walker (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctrl_i(ctrl_i),
    .start_addr_i(start_addr_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i), .per_valid_o(per_valid_o),
    .per_data_o(per_data_o), .per_ready_i(per_ready_i), .busy_o(busy_o),
    .done_o(done_o), .words_o(words_o), .final_ptr_o(final_ptr_o), .cause_o(cause_o)
  );

  always #10 clk = ~clk;  // 50 MHz

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [31:0] mem [0:1023];
  logic [31:0] exp_q [$];
  int  done_seen = 0;
  bit  addr_bad = 1'b0;
  bit  stray = 1'b0;
  bit  req_seen = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Memory, peripheral and monitor, all on the falling edge.
  always @(negedge clk) begin
    cyc++;
    per_ready_i = cyc[0] | cyc[2];
    if (mem_req_o && !mem_ack_i) begin
      mem_ack_i   = 1'b1;
      mem_rdata_i = mem[mem_addr_o[11:2]];
    end else begin
      mem_ack_i = 1'b0;
    end
    if (mem_req_o) begin
      req_seen = 1'b1;
      if ((mem_addr_o & ~MASK) != 24'h0) addr_bad = 1'b1;
    end
    if (per_valid_o && per_ready_i) begin
      if (exp_q.size() == 0) stray = 1'b1;
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check(per_data_o == e, "R3", "payload word", per_data_o, e);
      end
    end
    if (done_o) done_seen++;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 32'hC0DE_0000 | i;
  endtask

  task automatic node(input logic [23:0] a, input logic [7:0] n, input logic [23:0] nxt);
    mem[a[11:2]] = {n, nxt};
  endtask

  // Independent model: pushes expected beats, returns expected results.
  task automatic model(input logic [23:0] sa, output logic [31:0] w,
                       output logic [23:0] fp, output logic [1:0] cs);
    logic [23:0] p, a, last, lo, hi;
    int nodes;
    bit stop;
    p = sa; w = 1; last = 24'hFFFFFF; lo = last; hi = last;
    nodes = 0; stop = 0; cs = 0;
    while (!stop) begin
      a = p & MASK;
      if (nodes == CAP) begin cs = 2; stop = 1; end
      else if (a == lo || a == hi) begin cs = 1; stop = 1; end
      else begin
        logic [31:0] h;
        if (a < last) lo = a; else hi = a;
        last = a;
        nodes++;
        h = mem[a[11:2]];
        w = w + h[31:24] + 1;
        for (int k = 1; k <= int'(h[31:24]); k++) begin
          logic [23:0] pa;
          pa = (a + 24'(4 * k)) & MASK;
          exp_q.push_back(mem[pa[11:2]]);
        end
        p = h[23:0];
        if (p[23]) begin cs = 0; stop = 1; end
      end
    end
    fp = p;
  endtask

  task automatic run(input logic [23:0] sa, input string req, input bit extra);
    logic [31:0] ew;
    logic [23:0] ep;
    logic [1:0]  ec;
    int t;
    model(sa, ew, ep, ec);
    done_seen = 0; stray = 0; addr_bad = 0;
    @(negedge clk);
    start_i = 1'b1; ctrl_i = 32'h0100_0401; start_addr_i = sa;
    @(negedge clk);
    start_i = 1'b0;
    if (extra) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1; start_addr_i = 24'h000700;  // R10: ignored while busy
      @(negedge clk);
      start_i = 1'b0;
    end
    t = 0;
    while (done_seen == 0 && t < 20000) begin @(negedge clk); t++; end
    check(done_seen == 1, "R10", {req, " done pulse"}, done_seen, 1);
    check(busy_o == 1'b0, "R10", {req, " busy cleared"}, busy_o, 0);
    check(words_o == ew, "R9", {req, " words"}, words_o, ew);
    check(final_ptr_o == ep, req, "final pointer", final_ptr_o, ep);
    check(cause_o == ec, req, "stop cause", cause_o, ec);
    check(exp_q.size() == 0 && !stray, "R4", {req, " beat count"}, exp_q.size(), 0);
    check(!addr_bad, "R5", {req, " address window"}, addr_bad, 0);
    @(negedge clk);
    check(done_o == 1'b0, "R10", {req, " done one cycle"}, done_o, 0);
    exp_q.delete();
  endtask

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy_o && !done_o && !mem_req_o && !per_valid_o, "R1", "control outputs",
          {busy_o, done_o, mem_req_o, per_valid_o}, 0);
    check(words_o == 0 && final_ptr_o == 0 && cause_o == 0, "R1", "result outputs",
          words_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R6 all-ones end marker, zero-length middle node (R4), restart ignored (R10)
    node(24'h040, 8'd2, 24'h000080);
    node(24'h080, 8'd0, 24'h0000C0);
    node(24'h0C0, 8'd3, 24'hFFFFFF);
    run(24'h000040, "R6", 1'b1);

    // R6 bare bit-23 marker, unaligned start above window (R5)
    clear_mem();
    node(24'h100, 8'd1, 24'h000140);
    node(24'h140, 8'd4, 24'h800000);
    run(24'hE00103, "R6", 1'b0);

    // R7 ascending three-node cycle with high pointer bits
    clear_mem();
    node(24'h200, 8'd1, 24'h000300);
    node(24'h300, 8'd2, 24'h000400);
    node(24'h400, 8'd1, 24'h400202);
    run(24'h000200, "R7", 1'b0);

    // R7 descending two-node cycle: fetched three times
    clear_mem();
    node(24'h500, 8'd2, 24'h000380);
    node(24'h380, 8'd1, 24'h000500);
    run(24'h000500, "R7", 1'b0);

    // R7 self loop
    clear_mem();
    node(24'h700, 8'd2, 24'h000700);
    run(24'h000700, "R7", 1'b0);

    // R8 node limit on a long acyclic chain
    clear_mem();
    for (int i = 0; i < 8; i++)
      node(24'(24'h600 + 32 * i), 8'(i % 3), (i == 7) ? 24'hFFFFFF : 24'(24'h600 + 32 * (i + 1)));
    run(24'h000600, "R8", 1'b0);

    // R9 full-length payload
    clear_mem();
    node(24'h800, 8'd255, 24'hA00010);
    run(24'h000800, "R9", 1'b0);

    // R2 wrong control value is ignored
    req_seen = 1'b0; done_seen = 0;
    @(negedge clk);
    start_i = 1'b1; ctrl_i = 32'h0100_0201; start_addr_i = 24'h000040;
    @(negedge clk);
    start_i = 1'b0;
    repeat (20) @(negedge clk);
    check(!busy_o && !req_seen && done_seen == 0, "R2", "ignored start",
          {busy_o, req_seen}, 0);
    check(words_o == 32'd256 + 32'd1, "R2", "results kept", words_o, 257);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule